// File: doc/BRIEF.md
# LCD Parallel Pixel Format Serializer

This block sits between a display controller and a system-interface LCD panel. It takes one pixel per valid/ready handshake, either RGB565 or RGB888, and drives it onto an 18-bit parallel bus. Depending on a 3-bit format select, the pixel goes out as one, two or three bus beats. Some formats pack the pixel's bits into uneven 9-bit or 18-bit splits. Each beat is shown with a write strobe and a register-select level. The beat is held until the panel side acknowledges it.

A bus-width mode bit must agree with the chosen format. The byte-wide formats need it set, and every other format needs it clear. A pixel that arrives with a disagreeing setting, or with an unused format code, latches a sticky configuration error. From then on the bus stays silent until reset. The block also passes the data-enable and vertical-sync timing lines through one register stage, each with its own optional inversion.

Top module: `lcd_pix_serializer`

## Requirements
- R1: After reset, pix_ready is 1, bus_wr is 0, bus_data is 0, and cfg_err is 0. bus_data reads 0 whenever bus_wr is 0.
- R2: Format 3'b000 (byte mode 1) with RGB565 in pix_data[15:0] sends two beats, pix_data[7:0] first and then pix_data[15:8], each zero-extended.
- R3: Format 3'b110 (byte mode 0) sends one beat carrying pix_data[15:0].
- R4: Format 3'b001 (byte mode 1) with RGB888, where red is pix_data[23:16], green is [15:8] and blue is [7:0], sends three beats in the order red, green, blue.
- R5: Format 3'b011 (byte mode 0) takes the top six bits of each colour (r6, g6, b6). It sends {g6[2:0], r6} and then {b6, g6[5:3]}.
- R6: Format 3'b101 (byte mode 0) sends one beat {R[7:3], G[7:2], B[7:3]}.
- R7: Format 3'b111 (byte mode 0) sends {b6[3:0], g6, r6} and then b6[5:4].
- R8: A pixel accepted with an unused format code (3'b010 or 3'b100), or with a byte-mode bit that disagrees with its format, sets cfg_err. The error holds until reset. While it is set, no beat is driven and pix_ready stays 1, so later pixels are dropped.
- R9: A beat stays on bus_data with bus_wr high until bus_ack is seen at a clock edge. pix_ready is 0 while beats remain. During the last beat, pix_ready follows bus_ack, so a new pixel can be taken in the same cycle.
- R10: The format select and byte-mode bit are sampled only when a pixel is accepted. Changing them during a pixel's beats has no effect on that pixel.
- R11: de_out and vs_out equal, one clock later, de_in and vs_in XOR-ed with their own active-low control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_sel | input | 3 | Output format code |
| byte_mode | input | 1 | Bus-width mode bit, 1 for the byte-wide formats |
| pix_valid | input | 1 | Pixel offered |
| pix_data | input | 24 | Pixel, RGB888 or RGB565 in bits [15:0] |
| pix_ready | output | 1 | Block can take a pixel |
| bus_ack | input | 1 | Panel side takes the current beat |
| bus_data | output | 18 | Beat data |
| bus_wr | output | 1 | Write strobe, a beat is present |
| bus_rs | output | 1 | Register-select level, data level during beats |
| de_in | input | 1 | Data-enable from the controller |
| vs_in | input | 1 | Vertical sync from the controller |
| de_act_lo | input | 1 | Invert data-enable |
| vs_act_lo | input | 1 | Invert vertical sync |
| de_out | output | 1 | Registered data-enable |
| vs_out | output | 1 | Registered vertical sync |
| cfg_err | output | 1 | Sticky configuration error |

## Verification
All six formats are first run with one pixel whose red, green and blue bytes are all different and not symmetric. A swapped beat order, a shifted field or a truncation to the wrong bit therefore shows up as a wrong word. A second pixel with other bit patterns is then checked against a model in the bench that computes the beats by direct bit slicing. This separates packings that happen to agree on the first pixel. Directed cases cover the rest. One holds a beat without acknowledge. One overlaps the last beat with the next pixel. One changes the format during a pixel, and one supplies each kind of bad configuration. The polarity lines are driven in both senses.

// File: rtl/lcd_ser_pkg.sv
package lcd_ser_pkg;

  localparam int PIX_W = 24;
  localparam int BUS_W = 18;
  localparam int FMT_W = 3;
  localparam int IDX_W = 2;

  typedef enum logic [FMT_W-1:0] {
    FMT_B8_565  = 3'b000,
    FMT_B8_888  = 3'b001,
    FMT_B9_888  = 3'b011,
    FMT_B16_888 = 3'b101,
    FMT_B16_565 = 3'b110,
    FMT_B18_888 = 3'b111
  } fmt_e;

  function automatic logic fmt_known(input logic [FMT_W-1:0] f);
    return (f != 3'b010) && (f != 3'b100);
  endfunction

  function automatic logic fmt_is_byte(input logic [FMT_W-1:0] f);
    return (f == FMT_B8_565) || (f == FMT_B8_888);
  endfunction

  function automatic logic [IDX_W-1:0] beat_count(input logic [FMT_W-1:0] f);
    case (f)
      FMT_B8_888:               return 2'd3;
      FMT_B16_565, FMT_B16_888: return 2'd1;
      default:                  return 2'd2;
    endcase
  endfunction

  // Beat word k of a pixel in format f.
  function automatic logic [BUS_W-1:0] beat_word(input logic [FMT_W-1:0] f,
                                                 input logic [PIX_W-1:0] p,
                                                 input logic [IDX_W-1:0] k);
    logic [7:0] r8, g8, b8;
    logic [5:0] r6, g6, b6;
    logic [BUS_W-1:0] w;
    r8 = p[23:16];
    g8 = p[15:8];
    b8 = p[7:0];
    r6 = r8[7:2];
    g6 = g8[7:2];
    b6 = b8[7:2];
    w  = '0;
    case (f)
      FMT_B8_565:  w[7:0]  = (k == 2'd0) ? p[7:0] : p[15:8];
      FMT_B16_565: w[15:0] = p[15:0];
      FMT_B8_888:  w[7:0]  = (k == 2'd0) ? r8 : ((k == 2'd1) ? g8 : b8);
      FMT_B9_888:  w[8:0]  = (k == 2'd0) ? {g6[2:0], r6} : {b6, g6[5:3]};
      FMT_B16_888: w[15:0] = {r8[7:3], g6, b8[7:3]};
      FMT_B18_888: w[15:0] = (k == 2'd0) ? {b6[3:0], g6, r6} : {14'd0, b6[5:4]};
      default:     w       = '0;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/lcd_ser_cfg_check.sv
module lcd_ser_cfg_check
  import lcd_ser_pkg::*;
(
  input  logic [FMT_W-1:0] fmt,
  input  logic             byte_mode,
  output logic             cfg_ok
);
  always_comb begin
    cfg_ok = fmt_known(fmt) && (fmt_is_byte(fmt) == byte_mode);
  end
endmodule

// File: rtl/lcd_ser_beat_seq.sv
module lcd_ser_beat_seq
  import lcd_ser_pkg::*;
#(
  parameter logic RS_DATA_LEVEL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [FMT_W-1:0] load_fmt,
  input  logic [PIX_W-1:0] load_pix,
  input  logic             bus_ack,
  output logic             busy,
  output logic             last,
  output logic [BUS_W-1:0] bus_data,
  output logic             bus_wr,
  output logic             bus_rs
);
  logic [FMT_W-1:0] fmt_q;
  logic [PIX_W-1:0] pix_q;
  logic [IDX_W-1:0] idx_q;
  logic             busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q  <= '0;
      pix_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      fmt_q  <= load_fmt;
      pix_q  <= load_pix;
      idx_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q && bus_ack) begin
      if (last) busy_q <= 1'b0;
      else      idx_q  <= idx_q + 1'b1;
    end
  end

  always_comb begin
    busy     = busy_q;
    last     = busy_q && (idx_q == beat_count(fmt_q) - 1'b1);
    bus_wr   = busy_q;
    bus_rs   = busy_q ? RS_DATA_LEVEL : ~RS_DATA_LEVEL;
    bus_data = busy_q ? beat_word(fmt_q, pix_q, idx_q) : '0;
  end
endmodule

// File: rtl/lcd_ser_sync_pol.sv
module lcd_ser_sync_pol #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] sig_in,
  input  logic [LANES-1:0] act_lo,
  output logic [LANES-1:0] sig_out
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sig_out[i] <= 1'b0;
      else        sig_out[i] <= sig_in[i] ^ act_lo[i];
    end
  end
endmodule

// File: rtl/lcd_pix_serializer.sv
module lcd_pix_serializer
  import lcd_ser_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       fmt_sel,
  input  logic             byte_mode,
  input  logic             pix_valid,
  input  logic [23:0]      pix_data,
  output logic             pix_ready,
  input  logic             bus_ack,
  output logic [17:0]      bus_data,
  output logic             bus_wr,
  output logic             bus_rs,
  input  logic             de_in,
  input  logic             vs_in,
  input  logic             de_act_lo,
  input  logic             vs_act_lo,
  output logic             de_out,
  output logic             vs_out,
  output logic             cfg_err
);
  logic cfg_ok;
  logic seq_busy, seq_last;
  logic accept, accept_ok, accept_bad;
  logic err_q;

  lcd_ser_cfg_check u_cfg (
    .fmt       (fmt_sel),
    .byte_mode (byte_mode),
    .cfg_ok    (cfg_ok)
  );

  always_comb begin
    pix_ready  = err_q || !seq_busy || (seq_last && bus_ack);
    accept     = pix_valid && pix_ready;
    accept_ok  = accept && cfg_ok && !err_q;
    accept_bad = accept && !cfg_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          err_q <= 1'b0;
    else if (accept_bad) err_q <= 1'b1;
  end

  lcd_ser_beat_seq #(.RS_DATA_LEVEL(1'b1)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept_ok),
    .load_fmt (fmt_sel),
    .load_pix (pix_data),
    .bus_ack  (bus_ack),
    .busy     (seq_busy),
    .last     (seq_last),
    .bus_data (bus_data),
    .bus_wr   (bus_wr),
    .bus_rs   (bus_rs)
  );

  logic [1:0] sync_o;
  lcd_ser_sync_pol #(.LANES(2)) u_pol (
    .clk     (clk),
    .rst_n   (rst_n),
    .sig_in  ({vs_in, de_in}),
    .act_lo  ({vs_act_lo, de_act_lo}),
    .sig_out (sync_o)
  );

  always_comb begin
    de_out  = sync_o[0];
    vs_out  = sync_o[1];
    cfg_err = err_q;
  end
endmodule

// File: rtl/lcd_pix_serializer_chk.sv
module lcd_pix_serializer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pix_ready,
  input logic        bus_ack,
  input logic [17:0] bus_data,
  input logic        bus_wr,
  input logic        cfg_err,
  input logic        seq_busy,
  input logic        seq_last,
  input logic        accept_ok,
  input logic        de_in,
  input logic        de_act_lo,
  input logic        de_out,
  input logic        vs_in,
  input logic        vs_act_lo,
  input logic        vs_out
);
  p_idle_bus_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |-> bus_data == 18'd0);

  p_hold_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && !bus_ack |=> bus_wr && $stable(bus_data));

  p_no_ready_mid_pixel_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy && !seq_last |-> !pix_ready);

  p_accept_starts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ok |=> bus_wr);

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  p_err_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !bus_wr && pix_ready);

  p_de_pol_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> de_out == ($past(de_in) ^ $past(de_act_lo)));

  p_vs_pol_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> vs_out == ($past(vs_in) ^ $past(vs_act_lo)));
endmodule

bind lcd_pix_serializer lcd_pix_serializer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pix_ready (pix_ready),
  .bus_ack   (bus_ack),
  .bus_data  (bus_data),
  .bus_wr    (bus_wr),
  .cfg_err   (cfg_err),
  .seq_busy  (seq_busy),
  .seq_last  (seq_last),
  .accept_ok (accept_ok),
  .de_in     (de_in),
  .de_act_lo (de_act_lo),
  .de_out    (de_out),
  .vs_in     (vs_in),
  .vs_act_lo (vs_act_lo),
  .vs_out    (vs_out)
);

// File: tb/lcd_pix_serializer_tb.sv
`timescale 1ns/1ps
module lcd_pix_serializer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  fmt_sel = '0;
  logic        byte_mode = 1'b0;
  logic        pix_valid = 1'b0;
  logic [23:0] pix_data = '0;
  logic        pix_ready;
  logic        bus_ack = 1'b0;
  logic [17:0] bus_data;
  logic        bus_wr, bus_rs;
  logic        de_in = 1'b0, vs_in = 1'b0, de_act_lo = 1'b0, vs_act_lo = 1'b0;
  logic        de_out, vs_out, cfg_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lcd_pix_serializer u_dut (.*);

  typedef struct packed {
    logic [2:0]  fmt;
    logic        mode;
    logic [23:0] pix;
    logic [1:0]  n;
    logic [17:0] b0, b1, b2;
  } vec_t;

  // Pixel A5_3C_E7: R=A5 G=3C B=E7
  localparam vec_t VECS [6] = '{
    '{3'b000, 1'b1, 24'hA53CE7, 2'd2, 18'h000E7, 18'h0003C, 18'h0},
    '{3'b110, 1'b0, 24'hA53CE7, 2'd1, 18'h03CE7, 18'h0,     18'h0},
    '{3'b001, 1'b1, 24'hA53CE7, 2'd3, 18'h000A5, 18'h0003C, 18'h000E7},
    '{3'b011, 1'b0, 24'hA53CE7, 2'd2, 18'h001E9, 18'h001C9, 18'h0},
    '{3'b101, 1'b0, 24'hA53CE7, 2'd1, 18'h0A1FC, 18'h0,     18'h0},
    '{3'b111, 1'b0, 24'hA53CE7, 2'd2, 18'h093E9, 18'h00003, 18'h0}
  };

  function automatic string req_of(input logic [2:0] f);
    case (f)
      3'b000: return "R2";
      3'b110: return "R3";
      3'b001: return "R4";
      3'b011: return "R5";
      3'b101: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Bench model of the beat words, by direct bit slicing.
  function automatic logic [17:0] model_word(input logic [2:0] f, input logic [23:0] p,
                                             input int k);
    logic [7:0] r, g, b;
    {r, g, b} = p;
    case (f)
      3'b000: return (k == 0) ? {10'd0, b} : {10'd0, g};
      3'b110: return {2'd0, g, b};
      3'b001: return (k == 0) ? {10'd0, r} : (k == 1) ? {10'd0, g} : {10'd0, b};
      3'b011: return (k == 0) ? {9'd0, g[4:2], r[7:2]} : {9'd0, b[7:2], g[7:5]};
      3'b101: return {2'd0, r[7:3], g[7:2], b[7:3]};
      default: return (k == 0) ? {2'd0, b[5:2], g[7:2], r[7:2]} : {16'd0, b[7:6]};
    endcase
  endfunction

  function automatic int model_n(input logic [2:0] f);
    return (f == 3'b001) ? 3 : ((f == 3'b110 || f == 3'b101) ? 1 : 2);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pix_valid = 1'b0;
    bus_ack = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic run_pixel(input string req, input logic [2:0] f, input logic m,
                           input logic [23:0] p, input int n,
                           input logic [17:0] e0, input logic [17:0] e1,
                           input logic [17:0] e2);
    logic [17:0] ex [3];
    ex[0] = e0; ex[1] = e1; ex[2] = e2;
    @(negedge clk);
    fmt_sel = f; byte_mode = m; pix_data = p; pix_valid = 1'b1;
    #1 chk(req, "ready before accept", {31'd0, pix_ready}, 32'd1);
    @(negedge clk);
    pix_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      #1;
      chk(req, "bus_wr", {31'd0, bus_wr}, 32'd1);
      chk(req, "beat", {14'd0, bus_data}, {14'd0, ex[k]});
      chk("R9", "ready low mid pixel", {31'd0, pix_ready}, 32'd0);
      if (k == 0) begin
        @(negedge clk);
        #1 chk("R9", "beat held without ack", {14'd0, bus_data}, {14'd0, ex[k]});
      end
      bus_ack = 1'b1;
      @(negedge clk);
      bus_ack = 1'b0;
    end
    #1;
    chk(req, "bus idle after pixel", {31'd0, bus_wr}, 32'd0);
    chk("R1", "idle bus zero", {14'd0, bus_data}, 32'd0);
    chk("R9", "ready after pixel", {31'd0, pix_ready}, 32'd1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    do_reset();
    // R1 reset state
    chk("R1", "ready", {31'd0, pix_ready}, 32'd1);
    chk("R1", "bus_wr", {31'd0, bus_wr}, 32'd0);
    chk("R1", "bus_data", {14'd0, bus_data}, 32'd0);
    chk("R1", "cfg_err", {31'd0, cfg_err}, 32'd0);

    // Table walk
    foreach (VECS[i]) begin
      run_pixel(req_of(VECS[i].fmt), VECS[i].fmt, VECS[i].mode, VECS[i].pix,
                int'(VECS[i].n), VECS[i].b0, VECS[i].b1, VECS[i].b2);
    end

    // Second pattern against the bench model
    foreach (VECS[i]) begin
      logic [23:0] p2;
      p2 = 24'h5AC318;
      run_pixel(req_of(VECS[i].fmt), VECS[i].fmt, VECS[i].mode, p2,
                model_n(VECS[i].fmt), model_word(VECS[i].fmt, p2, 0),
                model_word(VECS[i].fmt, p2, 1), model_word(VECS[i].fmt, p2, 2));
    end

    // R10: format change mid pixel is ignored
    @(negedge clk);
    fmt_sel = 3'b001; byte_mode = 1'b1; pix_data = 24'h123456; pix_valid = 1'b1;
    @(negedge clk);
    pix_valid = 1'b0; fmt_sel = 3'b110; byte_mode = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1 chk("R10", "beat under changed select", {14'd0, bus_data},
             {14'd0, model_word(3'b001, 24'h123456, k)});
      bus_ack = 1'b1;
      @(negedge clk);
      bus_ack = 1'b0;
    end
    #1 chk("R10", "three beats only", {31'd0, bus_wr}, 32'd0);

    // R9: back-to-back on last beat
    @(negedge clk);
    fmt_sel = 3'b110; byte_mode = 1'b0; pix_data = 24'h00BEEF; pix_valid = 1'b1;
    @(negedge clk);
    fmt_sel = 3'b101; pix_data = 24'hFF00FF; bus_ack = 1'b1;
    #1 chk("R9", "ready follows ack on last beat", {31'd0, pix_ready}, 32'd1);
    @(negedge clk);
    pix_valid = 1'b0; bus_ack = 1'b0;
    #1;
    chk("R9", "next pixel beat", {14'd0, bus_data},
        {14'd0, model_word(3'b101, 24'hFF00FF, 0)});
    chk("R9", "next pixel strobe", {31'd0, bus_wr}, 32'd1);
    bus_ack = 1'b1;
    @(negedge clk);
    bus_ack = 1'b0;

    // R8: mode mismatch
    do_reset();
    @(negedge clk);
    fmt_sel = 3'b000; byte_mode = 1'b0; pix_data = 24'h0000AA; pix_valid = 1'b1;
    @(negedge clk);
    #1;
    chk("R8", "cfg_err on mismatch", {31'd0, cfg_err}, 32'd1);
    chk("R8", "no beat on mismatch", {31'd0, bus_wr}, 32'd0);
    chk("R8", "ready stays high", {31'd0, pix_ready}, 32'd1);
    fmt_sel = 3'b110; byte_mode = 1'b0;
    @(negedge clk);
    pix_valid = 1'b0;
    #1;
    chk("R8", "good pixel dropped after error", {31'd0, bus_wr}, 32'd0);
    chk("R8", "error sticky", {31'd0, cfg_err}, 32'd1);

    // R8: unused code
    do_reset();
    chk("R8", "reset clears error", {31'd0, cfg_err}, 32'd0);
    @(negedge clk);
    fmt_sel = 3'b010; byte_mode = 1'b0; pix_valid = 1'b1;
    @(negedge clk);
    pix_valid = 1'b0;
    #1;
    chk("R8", "cfg_err on unused code", {31'd0, cfg_err}, 32'd1);
    chk("R8", "no beat on unused code", {31'd0, bus_wr}, 32'd0);

    // R11: polarity
    do_reset();
    @(negedge clk);
    de_in = 1'b1; de_act_lo = 1'b0; vs_in = 1'b0; vs_act_lo = 1'b1;
    @(negedge clk);
    #1;
    chk("R11", "de straight", {31'd0, de_out}, 32'd1);
    chk("R11", "vs inverted", {31'd0, vs_out}, 32'd1);
    de_act_lo = 1'b1; vs_in = 1'b1;
    @(negedge clk);
    #1;
    chk("R11", "de inverted", {31'd0, de_out}, 32'd0);
    chk("R11", "vs inverted high in", {31'd0, vs_out}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule